// File: doc/BRIEF.md
# Reset and Programming Mode Entry Detector

This block watches the external reset pin and the program-store strobe pin. It decides when the chip's internal reset is asserted and which operating mode the chip enters once reset is released. A clock-generator tick that marks each machine cycle paces all timing decisions. Both pins pass through a two-flop synchronizer before the block uses them.

While the reset pin is high, a saturating counter counts machine-cycle ticks. Once two ticks have been counted, the internal reset asserts and the mode flag clears to normal operation. If the strobe pin then falls while reset is still held and more than ten ticks have been counted, the block latches external host programming mode. The internal reset drops on the first tick after the synchronized reset level goes low. The mode flag keeps its value until the next reset sequence begins.

Top module: `boot_mode_detect`

## Requirements
- R1: The tick counter advances only on ticks seen while the synchronized reset level is high, and it returns to zero whenever that level is low. A high pulse of one tick, followed by a low gap, followed by another single tick, therefore does not reach the reset threshold.
- R2: `sysRst` asserts once two ticks have been counted with the reset pin held high. One tick is not enough.
- R3: `sysRst` stays high after the reset pin goes low until the next tick arrives, and it is low after that tick.
- R4: `hostMode` becomes 1 when a high-to-low transition of the synchronized strobe level occurs while reset is held and the count is at least 11.
- R5: A strobe fall when the count is 10 or less leaves `hostMode` at 0 (normal operation).
- R6: With no strobe fall during reset, `hostMode` is 0 after release.
- R7: After release, `hostMode` holds its value, and a strobe fall while the reset pin is low changes neither output.
- R8: A new assertion of `sysRst` clears `hostMode` to 0.
- R9: After power-on reset (`porN` low), `sysRst` and `hostMode` are both 0.
- R10: The counter saturates at its maximum value. A reset hold far longer than the counter range still allows host mode entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| mcTick | input | 1 | One-clock pulse per machine cycle |
| rstPin | input | 1 | External reset pin level, asynchronous, active high |
| psenPin | input | 1 | Program-store strobe pin level, asynchronous |
| sysRst | output | 1 | Internal reset, active high |
| hostMode | output | 1 | 1 = external host programming mode, 0 = normal |

## Verification
The main function is exercised with reset holds of 1, 3, 10, 11, 12, 15 and 20 ticks, with and without a strobe fall. The 10/11 pair separates a strict comparison from a non-strict one. The 20-tick hold checks that saturation does not wrap the counter back below the threshold. The no-fall hold placed right after a host-mode run shows that a new reset clears the mode. A split one-tick pulse shows that the counter clears when the pin goes low. A strobe fall with the reset pin low shows that the latched mode ignores it.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntCmd_t;

  typedef struct packed {
    logic rstHigh;
    logic psenFall;
    logic cntAtRst;
    logic cntPastHost;
  } dpStat_t;
endpackage

// File: rtl/boot_mode_dp.sv
module boot_mode_dp
  import boot_mode_pkg::*;
#(
  parameter int SYNC_N   = 2,
  parameter int CNT_W    = 4,
  parameter int RST_CYC  = 2,
  parameter int HOST_CYC = 10
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstPin,
  input  logic             psenPin,
  input  cntCmd_t          cmd,
  output dpStat_t          stat,
  output logic [CNT_W-1:0] hiCnt
);
  localparam logic [CNT_W-1:0] RST_LIM  = CNT_W'(RST_CYC);
  localparam logic [CNT_W-1:0] HOST_LIM = CNT_W'(HOST_CYC);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  logic [SYNC_N-1:0] rstSync;
  logic [SYNC_N-1:0] psenSync;
  logic              psenPrev;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstSync  <= '0;
      psenSync <= '1;
    end else begin
      rstSync  <= {rstSync[SYNC_N-2:0], rstPin};
      psenSync <= {psenSync[SYNC_N-2:0], psenPin};
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) psenPrev <= 1'b1;
    else       psenPrev <= psenSync[SYNC_N-1];
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                            hiCnt <= '0;
    else if (cmd.cntClr)                  hiCnt <= '0;
    else if (cmd.cntInc && hiCnt != CNT_MAX) hiCnt <= hiCnt + 1'b1;
  end

  always_comb begin
    stat.rstHigh     = rstSync[SYNC_N-1];
    stat.psenFall    = psenPrev & ~psenSync[SYNC_N-1];
    stat.cntAtRst    = hiCnt >= RST_LIM;
    stat.cntPastHost = hiCnt > HOST_LIM;
  end
endmodule

// File: rtl/boot_mode_ctl.sv
module boot_mode_ctl
  import boot_mode_pkg::*;
(
  input  logic    clk,
  input  logic    porN,
  input  logic    mcTick,
  input  dpStat_t stat,
  output cntCmd_t cmd,
  output logic    sysRst,
  output logic    hostMode
);
  always_comb begin
    cmd.cntClr = ~stat.rstHigh;
    cmd.cntInc = stat.rstHigh & mcTick;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sysRst   <= 1'b0;
      hostMode <= 1'b0;
    end else if (!sysRst) begin
      if (stat.rstHigh && stat.cntAtRst) begin
        sysRst   <= 1'b1;
        hostMode <= 1'b0;
      end
    end else begin
      if (!stat.rstHigh && mcTick) sysRst <= 1'b0;
      if (stat.rstHigh && stat.psenFall && stat.cntPastHost) hostMode <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_mode_detect.sv
module boot_mode_detect
  import boot_mode_pkg::*;
#(
  parameter int SYNC_N   = 2,
  parameter int CNT_W    = 4,
  parameter int RST_CYC  = 2,
  parameter int HOST_CYC = 10
) (
  input  logic clk,
  input  logic porN,
  input  logic mcTick,
  input  logic rstPin,
  input  logic psenPin,
  output logic sysRst,
  output logic hostMode
);
  cntCmd_t          cmd;
  dpStat_t          stat;
  logic [CNT_W-1:0] hiCnt;

  boot_mode_dp #(
    .SYNC_N(SYNC_N), .CNT_W(CNT_W), .RST_CYC(RST_CYC), .HOST_CYC(HOST_CYC)
  ) dp (
    .clk(clk), .porN(porN), .rstPin(rstPin), .psenPin(psenPin),
    .cmd(cmd), .stat(stat), .hiCnt(hiCnt)
  );

  boot_mode_ctl ctl (
    .clk(clk), .porN(porN), .mcTick(mcTick), .stat(stat),
    .cmd(cmd), .sysRst(sysRst), .hostMode(hostMode)
  );
endmodule

// File: rtl/boot_mode_chk.sv
module boot_mode_chk #(
  parameter int CNT_W    = 4,
  parameter int RST_CYC  = 2,
  parameter int HOST_CYC = 10
) (
  input logic             clk,
  input logic             porN,
  input logic             mcTick,
  input logic             rstHigh,
  input logic             psenFall,
  input logic [CNT_W-1:0] hiCnt,
  input logic             sysRst,
  input logic             hostMode
);
  assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (!porN)
    !rstHigh |=> hiCnt == '0);

  assert_rst_threshold_R2: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRst) |-> $past(hiCnt) >= CNT_W'(RST_CYC));

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> $past(mcTick && !rstHigh));

  assert_host_entry_R4: assert property (@(posedge clk) disable iff (!porN)
    $rose(hostMode) |-> $past(rstHigh && psenFall && (hiCnt > CNT_W'(HOST_CYC))));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!porN)
    (hostMode != $past(hostMode)) |-> sysRst);

  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRst) |-> !hostMode);
endmodule

bind boot_mode_detect boot_mode_chk #(
  .CNT_W(CNT_W), .RST_CYC(RST_CYC), .HOST_CYC(HOST_CYC)
) chk (
  .clk(clk), .porN(porN), .mcTick(mcTick), .rstHigh(stat.rstHigh),
  .psenFall(stat.psenFall), .hiCnt(hiCnt), .sysRst(sysRst), .hostMode(hostMode)
);

// File: tb/boot_mode_detect_test.sv
module boot_mode_detect_test;
  logic clk = 1'b0;
  logic porN = 1'b0;
  logic mcTick = 1'b0;
  logic rstPin = 1'b0;
  logic psenPin = 1'b1;
  logic sysRst, hostMode;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  boot_mode_detect uut (
    .clk(clk), .porN(porN), .mcTick(mcTick), .rstPin(rstPin),
    .psenPin(psenPin), .sysRst(sysRst), .hostMode(hostMode)
  );

  // fields: ticks[9:2], strobe fall[1], expected hostMode[0]
  localparam int NV = 7;
  localparam logic [9:0] VEC [NV] = '{
    {8'd1,  1'b0, 1'b0},
    {8'd3,  1'b1, 1'b0},
    {8'd11, 1'b1, 1'b1},
    {8'd12, 1'b0, 1'b0},
    {8'd10, 1'b1, 1'b0},
    {8'd20, 1'b1, 1'b1},
    {8'd15, 1'b1, 1'b1}
  };

  task automatic check(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) mcTick = 1'b1;
    @(negedge clk) mcTick = 1'b0;
    waitClk(2);
  endtask

  task automatic fallPsen();
    @(negedge clk) psenPin = 1'b0;
    waitClk(4);
    psenPin = 1'b1;
    waitClk(4);
  endtask

  task automatic runSeq(int ticks, bit doFall, bit expHost);
    logic expRst;
    expRst = (ticks >= 2);
    @(negedge clk) rstPin = 1'b1;
    waitClk(4);
    for (int i = 0; i < ticks; i++) tick();
    check("R2", sysRst, expRst);
    if (expRst) check("R8", hostMode, 1'b0);
    if (doFall) fallPsen();
    @(negedge clk) rstPin = 1'b0;
    waitClk(4);
    check("R3", sysRst, expRst);
    tick();
    check("R3", sysRst, 1'b0);
    if (doFall && ticks >= 11) check("R4", hostMode, expHost);
    else if (doFall) check("R5", hostMode, expHost);
    else check("R6", hostMode, expHost);
    if (ticks > 15) check("R10", hostMode, expHost);
  endtask

  initial begin
    waitClk(3);
    check("R9", sysRst, 1'b0);
    check("R9", hostMode, 1'b0);
    porN = 1'b1;
    waitClk(2);

    for (int v = 0; v < NV; v++)
      runSeq(int'(VEC[v][9:2]), VEC[v][1], VEC[v][0]);

    // R7: mode held after release, strobe fall with reset pin low ignored
    runSeq(12, 1'b1, 1'b1);
    fallPsen();
    tick();
    check("R7", hostMode, 1'b1);
    check("R7", sysRst, 1'b0);

    // R1: split single-tick pulses do not accumulate
    @(negedge clk) rstPin = 1'b1;
    waitClk(4);
    tick();
    @(negedge clk) rstPin = 1'b0;
    waitClk(4);
    tick();
    @(negedge clk) rstPin = 1'b1;
    waitClk(4);
    tick();
    check("R1", sysRst, 1'b0);
    tick();
    check("R2", sysRst, 1'b1);
    check("R8", hostMode, 1'b0);
    @(negedge clk) rstPin = 1'b0;
    waitClk(4);
    tick();
    check("R3", sysRst, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule